// File: doc/BRIEF.md
# Multi-Channel Interrupt Vector Encoder

This block gathers the receive and transmit interrupt requests of eight serial channels, sixteen request lines in all. It raises one shared interrupt request toward the bus. When the daisy-chained acknowledge grant reaches it, it either absorbs the grant and supplies the vector of the winning source, or passes the grant unchanged to the next device on the chain when nothing is pending.

Each vector is built from three fields. A three-bit base setting from switches forms the top field. The channel number of the winning source forms the middle field. A direction bit selects receive (0) or transmit (1). The two lowest bits are always zero. A console option moves only channel 7's receive/transmit pair to the fixed vectors 060 and 064 (octal). The other seven channels keep their base-derived vectors.

All outputs are registered. The interrupt request, the vector, the vector-valid strobe and the passed-on grant all change on the clock edge after the inputs that cause them. The vector lines read zero whenever no vector is being presented. There is no back-pressure: a presented vector is valid for exactly one cycle.

Top module: `irq_vector_encoder`

## Requirements
- R1: A presented vector carries the base switches in bits 8:6, the channel number in bits 5:3, the direction in bit 2 (0 receive, 1 transmit) and zero in bits 1:0. With base 3, channel 0 gives 300/304 octal and channel 7 gives 370/374 octal.
- R2: Among simultaneous requests, the lowest channel number wins. Within one channel, receive wins over transmit.
- R3: With console mode on, channel 7 presents 060 octal for receive and 064 octal for transmit. Channels 0 to 6 are unaffected.
- R4: A grant that arrives with no request pending appears on ack_out in the following cycle. In that cycle vec_valid stays low and no vector is driven.
- R5: A grant that arrives while any request is pending is absorbed, so ack_out stays low. vec_valid is high for exactly the following cycle, with the winner's vector.
- R6: irq is high in the cycle after any request line is high, and low in the cycle after all request lines are low.
- R7: During and right after reset, irq, vec_valid, ack_out and vec are all zero.
- R8: The vector output is zero in every cycle where vec_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_req | input | 8 | Receive interrupt request, one line per channel |
| tx_req | input | 8 | Transmit interrupt request, one line per channel |
| base_sw | input | 3 | Base vector switches (vector bits 8:6) |
| console_en | input | 1 | Console mode: relocates channel 7's vector pair |
| ack_in | input | 1 | Acknowledge grant arriving from upstream |
| irq | output | 1 | Combined interrupt request |
| vec_valid | output | 1 | Vector is being presented this cycle |
| vec | output | 9 | Interrupt vector |
| ack_out | output | 1 | Acknowledge grant passed downstream |

## Verification
The embedded assertions check several properties on every cycle. The grant is never both passed on and absorbed. Vector alignment and idle-zero hold. irq follows the request lines. The priority pick is always a requesting source with no lower-indexed source also requesting. Only the bench's sweeps can show that the field packing, the console relocation and the winner choice produce the right numeric vector. The bench runs every base, every console setting, every single source and every pair of sources, and compares against values computed arithmetically.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/irqv_pick.sv
module irqv_pick #(
  parameter int SRC = 16,
  localparam int IDX_W = $clog2(SRC)
) (
  input  logic [SRC-1:0]   req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    idx = '0;
    for (int i = SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irqv_compose.sv
module irqv_compose
  import irqv_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int BASE_W = 3,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int VEC_W = BASE_W + CH_W + 3,
  parameter logic [VEC_W-1:0] CON_VEC = VEC_W'(9'o060)
) (
  input  logic [BASE_W-1:0] base,
  input  logic [CH_W-1:0]   ch,
  input  dir_e              dir,
  input  logic              console_en,
  output logic [VEC_W-1:0]  vec
);
  localparam logic [CH_W-1:0] CON_CH = CH_W'(NUM_CH - 1);

  always_comb begin
    if (console_en && ch == CON_CH)
      vec = CON_VEC | (VEC_W'(dir) << 2);
    else
      vec = {base, ch, dir, 2'b00};
  end
endmodule

// File: rtl/irq_vector_encoder.sv
module irq_vector_encoder
  import irqv_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int BASE_W = 3,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int SRC   = 2 * NUM_CH,
  localparam int IDX_W = $clog2(SRC),
  localparam int VEC_W = BASE_W + CH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] rx_req,
  input  logic [NUM_CH-1:0] tx_req,
  input  logic [BASE_W-1:0] base_sw,
  input  logic              console_en,
  input  logic              ack_in,
  output logic              irq,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec,
  output logic              ack_out
);
  logic [SRC-1:0]   src;
  logic             any_req;
  logic [IDX_W-1:0] win_idx;
  logic [CH_W-1:0]  win_ch;
  dir_e             win_dir;
  logic [VEC_W-1:0] cand_vec;
  logic             take;

  // interleave so index order is rx0, tx0, rx1, tx1, ...
  for (genvar g = 0; g < NUM_CH; g++) begin : g_src
    assign src[2*g]   = rx_req[g];
    assign src[2*g+1] = tx_req[g];
  end

  irqv_pick #(.SRC(SRC)) u_pick (
    .req (src),
    .any (any_req),
    .idx (win_idx)
  );

  assign win_ch  = win_idx[IDX_W-1:1];
  assign win_dir = dir_e'(win_idx[0]);

  irqv_compose #(.NUM_CH(NUM_CH), .BASE_W(BASE_W)) u_compose (
    .base       (base_sw),
    .ch         (win_ch),
    .dir        (win_dir),
    .console_en (console_en),
    .vec        (cand_vec)
  );

  assign take = ack_in & any_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      vec_valid <= 1'b0;
      vec       <= '0;
      ack_out   <= 1'b0;
    end else begin
      irq       <= any_req;
      vec_valid <= take;
      vec       <= take ? cand_vec : '0;
      ack_out   <= ack_in & ~any_req;
    end
  end

  // R2
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> (src[win_idx] && ((src & ((SRC'(1) << win_idx) - SRC'(1))) == '0)));

  // R4
  ack_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> $past(ack_in));

  // R5
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_out && vec_valid));

  // R1
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec[1:0] == 2'b00));

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec == '0));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> irq);
endmodule

// File: tb/irq_vector_encoder_tb.sv
module irq_vector_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_req, tx_req;
  logic [2:0] base_sw;
  logic       console_en, ack_in;
  logic       irq, vec_valid, ack_out;
  logic [8:0] vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_vector_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
    .base_sw(base_sw), .console_en(console_en), .ack_in(ack_in),
    .irq(irq), .vec_valid(vec_valid), .vec(vec), .ack_out(ack_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // source k: channel k/2, dir k%2 (0 rx, 1 tx)
  function automatic int exp_vec(input int k, input int base, input bit con);
    int ch = k / 2;
    int d  = k % 2;
    if (con && ch == 7) return 48 + 4 * d;
    return base * 64 + ch * 8 + d * 4;
  endfunction

  // drive at negedge, sample just after the next posedge
  task automatic apply(input logic [15:0] s, input int base, input bit con, input bit ack);
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      rx_req[c] = s[2*c];
      tx_req[c] = s[2*c+1];
    end
    base_sw = 3'(base); console_en = con; ack_in = ack;
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_req = '0; tx_req = '0; base_sw = 3'd3;
    console_en = 1'b0; ack_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    chk("R7 irq", int'(irq), 0);
    chk("R7 vec_valid", int'(vec_valid), 0);
    chk("R7 ack_out", int'(ack_out), 0);
    chk("R7 vec", int'(vec), 0);
    rst_n = 1'b1;

    // R4: grant with nothing pending passes through
    apply(16'h0000, 3, 1'b0, 1'b1);
    chk("R4 ack_out", int'(ack_out), 1);
    chk("R4 vec_valid", int'(vec_valid), 0);
    chk("R4 vec", int'(vec), 0);
    chk("R6 irq low", int'(irq), 0);

    // R1/R3/R5/R6/R8: every single source, every base, both console settings
    for (int con = 0; con < 2; con++) begin
      for (int b = 0; b < 8; b++) begin
        for (int k = 0; k < 16; k++) begin
          apply(16'(1) << k, b, con[0], 1'b1);
          chk(con ? "R3 vec" : "R1 vec", int'(vec), exp_vec(k, b, con[0]));
          chk("R5 vec_valid", int'(vec_valid), 1);
          chk("R5 ack_out", int'(ack_out), 0);
          chk("R6 irq", int'(irq), 1);
          // hold request, no grant: nothing presented
          apply(16'(1) << k, b, con[0], 1'b0);
          chk("R8 vec idle", int'(vec), 0);
          chk("R5 one cycle", int'(vec_valid), 0);
          chk("R4 no grant", int'(ack_out), 0);
        end
      end
    end

    // R2: every pair of sources, lower index wins
    for (int i = 0; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        apply((16'(1) << i) | (16'(1) << j), 5, 1'b1, 1'b1);
        chk("R2 winner", int'(vec), exp_vec(i, 5, 1'b1));
      end
    end

    // R2: all requesting; then R6 irq drops after release
    apply(16'hFFFF, 2, 1'b0, 1'b1);
    chk("R2 all", int'(vec), exp_vec(0, 2, 1'b0));
    apply(16'h0000, 2, 1'b0, 1'b0);
    chk("R6 irq release", int'(irq), 0);
    chk("R8 idle", int'(vec), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule